// File: doc/BRIEF.md
# Core Memory Read-Restore Cycle Controller

This block runs complete memory cycles on a coincident-current magnetic core array that holds words of `DATA_W` bits. A request carries an address, a write flag, write data and a zeroing-read flag. The block drives one X select line and one Y select line. A direction signal picks either the read sense (toward zero) or the write sense. During the write half it drives one inhibit enable per bit. It samples the per-bit sense inputs inside a strobe window. At the end of each cycle it returns the sensed word with a one-cycle done pulse.

Reading a core clears it, so every access is a read half followed by a write half. A normal read writes the captured word back. A write request discards the captured word and writes the new data. A zeroing read returns the data and skips the write half, which leaves the word cleared. With `FIXED_PLANE` set, the contents come from the wiring of a read-only plane. After reset, the controller reads every location of that plane once before it accepts user requests. During the write half it always drives the restore of the captured data, so write data and the zeroing flag have no effect on that plane. Every phase length is a parameter in clock cycles.

Top module: `core_cycle_ctrl`

## Requirements
- R1: While the array is driven, exactly one X line and exactly one Y line are active. The X index is the low `ADDR_W/2` address bits and the Y index is the remaining high bits. When the array is not driven, all select lines are low.
- R2: The read half lasts `RD_LEN` cycles with `drv_dir`=0. The sense inputs are sampled only while `strobe` is high, which is read-half cycles `STB_OFS` to `STB_OFS+STB_LEN-1`. A returned bit is 1 when its sense input was high in at least one strobed cycle. Sense activity outside the window is ignored.
- R3: After a normal read, the write half drives `drv_dir`=1 with `inhibit` set to the inverse of the captured word. The word therefore reads back unchanged on every later read.
- R4: A write request runs a read half, discards the sensed word and writes the request data with `inhibit` equal to its inverse. Its done pulse carries `rsp_rdata`=0. `inhibit` is 0 outside the write half.
- R5: On a plane that is not fixed, a zeroing read returns the stored word and has no write half. The next read of that address returns 0.
- R6: The phases run in this order: read half, `DEAD_LEN` dead cycles, `WR_LEN` write cycles, `REC_LEN` recovery cycles. Counted from the accepting clock edge, the done pulse appears `RD_LEN+DEAD_LEN+WR_LEN+REC_LEN` cycles later, or `RD_LEN+REC_LEN` cycles later for a zeroing read that skips the write half.
- R7: A request transfers when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only when no cycle is in progress and no priming pass is running. It stays low from the accepting edge until recovery ends.
- R8: With `FIXED_PLANE`=1, `busy_prime` is high from reset and `req_ready` is low while it is high. During this time the block reads addresses 0 to 2^`ADDR_W`-1 once each, in ascending order, with restore and with no done pulses. After the last of these reads, `busy_prime` drops and stays low.
- R9: With `FIXED_PLANE`=1, the write half always restores the captured word. Write data and the zeroing flag have no effect: later reads return the wired contents, and a zeroing read takes the full cycle length.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write request |
| req_zero | input | 1 | 1 = zeroing read (no restore) |
| req_wdata | input | DATA_W | Data for a write request |
| x_sel | output | 2**(ADDR_W/2) | One-hot X select drive |
| y_sel | output | 2**(ADDR_W-ADDR_W/2) | One-hot Y select drive |
| drive_en | output | 1 | Select currents on |
| drv_dir | output | 1 | 0 = read sense, 1 = write sense |
| inhibit | output | DATA_W | Per-bit inhibit enable in the write half |
| sense | input | DATA_W | Per-bit sense inputs |
| strobe | output | 1 | Sense sampling window |
| rsp_valid | output | 1 | Done pulse |
| rsp_rdata | output | DATA_W | Sensed word, 0 for writes |
| busy_prime | output | 1 | Start-up priming pass running |

## Verification
The core model in the bench raises every sense input on all read-half cycles outside the strobe window. A controller that samples too early or too late returns all ones instead of the stored word. The bench issues a zeroing read followed by a plain read, which catches a restore that runs anyway (the second read would return the old data) and a wrong length for the shortened cycle (the done pulse would arrive at the wrong cycle). A read-only plane is primed from reset while the bench records the order of the addresses. On that plane the bench then writes data and issues zeroing reads and checks that the wired words come back. A controller that skipped priming would return zeros there, and one that honoured the write data would return it.

// File: rtl/core_cycle_pkg.sv
package core_cycle_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_DEAD = 3'd2,
    PH_WR   = 3'd3,
    PH_REC  = 3'd4
  } phase_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold the longest phase index.
  function automatic int cnt_width(input int a, input int b, input int c, input int d);
    int m;
    m = max_of4(a, b, c, d);
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // True when cycle index k lies in [ofs, ofs+len).
  function automatic bit in_window(input int k, input int ofs, input int len);
    return (k >= ofs) && (k < ofs + len);
  endfunction

  // Length of a full cycle, with or without the write half.
  function automatic int cycle_len(input int rd, input int dead, input int wr,
                                   input int rec, input bit skip);
    return skip ? (rd + rec) : (rd + dead + wr + rec);
  endfunction

endpackage

// File: rtl/core_phase_timer.sv
module core_phase_timer
  import core_cycle_pkg::*;
#(
  parameter int RD_LEN   = 4,
  parameter int DEAD_LEN = 1,
  parameter int WR_LEN   = 3,
  parameter int REC_LEN  = 2,
  localparam int CW      = cnt_width(RD_LEN, DEAD_LEN, WR_LEN, REC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          skip_write,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          phase_last,
  output logic          cycle_end
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q;
  int            cur_len;

  always_comb begin
    case (ph_q)
      PH_RD:   cur_len = RD_LEN;
      PH_DEAD: cur_len = DEAD_LEN;
      PH_WR:   cur_len = WR_LEN;
      PH_REC:  cur_len = REC_LEN;
      default: cur_len = 1;
    endcase
  end

  assign phase_last = (int'(cnt_q) == cur_len - 1);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (start) ph_d = PH_RD;
      PH_RD:   if (phase_last) ph_d = skip_write ? PH_REC : PH_DEAD;
      PH_DEAD: if (phase_last) ph_d = PH_WR;
      PH_WR:   if (phase_last) ph_d = PH_REC;
      PH_REC:  if (phase_last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_d != ph_q) cnt_q <= '0;
      else if (ph_q != PH_IDLE) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase     = ph_q;
  assign cnt       = cnt_q;
  assign cycle_end = (ph_q == PH_REC) && phase_last;

endmodule

// File: rtl/core_sense_capture.sv
module core_sense_capture
  import core_cycle_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STB_OFS = 1,
  parameter int STB_LEN = 2,
  parameter int CW      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  phase_e            phase,
  input  logic [CW-1:0]     cnt,
  input  logic [DATA_W-1:0] sense,
  output logic              strobe,
  output logic [DATA_W-1:0] captured
);

  logic [DATA_W-1:0] cap_q;

  assign strobe = (phase == PH_RD) && in_window(int'(cnt), STB_OFS, STB_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (clear)  cap_q <= '0;
    else if (strobe) cap_q <= cap_q | sense;
  end

  assign captured = cap_q;

endmodule

// File: rtl/core_line_driver.sv
module core_line_driver
  import core_cycle_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int XA_W  = ADDR_W / 2,
  localparam int YA_W  = ADDR_W - XA_W,
  localparam int XN    = 1 << XA_W,
  localparam int YN    = 1 << YA_W
) (
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wval,
  output logic [XN-1:0]     x_sel,
  output logic [YN-1:0]     y_sel,
  output logic              drive_en,
  output logic              drv_dir,
  output logic [DATA_W-1:0] inhibit
);

  logic            active;
  logic [XA_W-1:0] xa;
  logic [YA_W-1:0] ya;

  assign active   = (phase == PH_RD) || (phase == PH_WR);
  assign drive_en = active;
  assign drv_dir  = (phase == PH_WR);
  assign xa       = addr[XA_W-1:0];
  assign ya       = addr[ADDR_W-1:XA_W];
  assign inhibit  = (phase == PH_WR) ? ~wval : '0;

  for (genvar i = 0; i < XN; i++) begin : g_x
    assign x_sel[i] = active && (xa == XA_W'(i));
  end
  for (genvar j = 0; j < YN; j++) begin : g_y
    assign y_sel[j] = active && (ya == YA_W'(j));
  end

endmodule

// File: rtl/core_prime_walker.sv
module core_prime_walker #(
  parameter int ADDR_W = 4,
  parameter bit ENABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= ENABLE;
      addr_q <= '0;
    end else if (step && busy_q) begin
      if (addr_q == {ADDR_W{1'b1}}) busy_q <= 1'b0;
      addr_q <= addr_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign addr = addr_q;

endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
  import core_cycle_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int RD_LEN      = 4,
  parameter int STB_OFS     = 1,
  parameter int STB_LEN     = 2,
  parameter int DEAD_LEN    = 1,
  parameter int WR_LEN      = 3,
  parameter int REC_LEN     = 2,
  parameter bit FIXED_PLANE = 1'b0,
  localparam int XN         = 1 << (ADDR_W / 2),
  localparam int YN         = 1 << (ADDR_W - ADDR_W / 2),
  localparam int CW         = cnt_width(RD_LEN, DEAD_LEN, WR_LEN, REC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_zero,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [XN-1:0]     x_sel,
  output logic [YN-1:0]     y_sel,
  output logic              drive_en,
  output logic              drv_dir,
  output logic [DATA_W-1:0] inhibit,
  input  logic [DATA_W-1:0] sense,
  output logic              strobe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy_prime
);

  phase_e            phase;
  logic [CW-1:0]     pcnt;
  logic              phase_last;
  logic              cycle_end;
  logic              in_idle;
  logic              in_cycle;
  logic              accept;
  logic              start;
  logic              skip_write;
  logic              prime_step;
  logic [ADDR_W-1:0] prime_addr;
  logic [DATA_W-1:0] captured;
  logic [DATA_W-1:0] wval;

  logic              op_prime_q;
  logic              op_write_q;
  logic              op_zero_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;

  assign in_idle    = (phase == PH_IDLE);
  assign in_cycle   = !in_idle;
  assign req_ready  = in_idle && !busy_prime;
  assign accept     = req_valid && req_ready;
  assign start      = accept || (in_idle && busy_prime);
  assign skip_write = op_zero_q && !FIXED_PLANE;
  assign prime_step = cycle_end && op_prime_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_prime_q <= 1'b0;
      op_write_q <= 1'b0;
      op_zero_q  <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
    end else if (start) begin
      op_prime_q <= busy_prime;
      op_write_q <= !busy_prime && req_write;
      op_zero_q  <= !busy_prime && req_zero;
      op_addr_q  <= busy_prime ? prime_addr : req_addr;
      op_wdata_q <= req_wdata;
    end
  end

  // A fixed plane always gets its captured word restored.
  assign wval = (op_write_q && !FIXED_PLANE) ? op_wdata_q : captured;

  core_phase_timer #(
    .RD_LEN(RD_LEN), .DEAD_LEN(DEAD_LEN), .WR_LEN(WR_LEN), .REC_LEN(REC_LEN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_write(skip_write),
    .phase(phase), .cnt(pcnt), .phase_last(phase_last), .cycle_end(cycle_end)
  );

  core_sense_capture #(
    .DATA_W(DATA_W), .STB_OFS(STB_OFS), .STB_LEN(STB_LEN), .CW(CW)
  ) u_sense (
    .clk(clk), .rst_n(rst_n), .clear(start), .phase(phase), .cnt(pcnt),
    .sense(sense), .strobe(strobe), .captured(captured)
  );

  core_line_driver #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_lines (
    .phase(phase), .addr(op_addr_q), .wval(wval),
    .x_sel(x_sel), .y_sel(y_sel), .drive_en(drive_en), .drv_dir(drv_dir),
    .inhibit(inhibit)
  );

  core_prime_walker #(
    .ADDR_W(ADDR_W), .ENABLE(FIXED_PLANE)
  ) u_prime (
    .clk(clk), .rst_n(rst_n), .step(prime_step),
    .busy(busy_prime), .addr(prime_addr)
  );

  assign rsp_valid = cycle_end && !op_prime_q;
  assign rsp_rdata = op_write_q ? '0 : captured;

endmodule

// File: rtl/core_cycle_ctrl_chk.sv
module core_cycle_ctrl_chk #(
  parameter int XN     = 4,
  parameter int YN     = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [XN-1:0]     x_sel,
  input logic [YN-1:0]     y_sel,
  input logic              drive_en,
  input logic              drv_dir,
  input logic [DATA_W-1:0] inhibit,
  input logic              strobe,
  input logic              rsp_valid,
  input logic              busy_prime,
  input logic              in_cycle,
  input logic              skip_write
);

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> ($onehot(x_sel) && $onehot(y_sel)));

  p_sel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (x_sel == '0 && y_sel == '0));

  p_strobe_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (drive_en && !drv_dir));

  p_inhibit_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && drv_dir) |-> (inhibit == '0));

  p_zero_no_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && skip_write) |-> !(drive_en && drv_dir));

  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_hold_while_prime_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_prime |-> !req_ready);

  p_prime_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_prime |=> !busy_prime);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind core_cycle_ctrl core_cycle_ctrl_chk #(
  .XN(XN), .YN(YN), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .x_sel(x_sel), .y_sel(y_sel), .drive_en(drive_en), .drv_dir(drv_dir),
  .inhibit(inhibit), .strobe(strobe), .rsp_valid(rsp_valid),
  .busy_prime(busy_prime), .in_cycle(in_cycle), .skip_write(skip_write)
);

// File: tb/core_cycle_ctrl_tb.sv
`timescale 1ns/1ps

module core_plane_model #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter bit FIXED = 1'b0
) (
  input  logic                      clk,
  input  logic [(1<<(AW/2))-1:0]    x_sel,
  input  logic [(1<<(AW-AW/2))-1:0] y_sel,
  input  logic                      drive_en,
  input  logic                      drv_dir,
  input  logic [DW-1:0]             inhibit,
  input  logic                      strobe,
  output logic [DW-1:0]             sense
);
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] snap;
  logic          in_rd;
  int            a;

  function automatic int oh_idx(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [DW-1:0] wired(input int k);
    return DW'(k * 37 + 5);
  endfunction

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    in_rd = 1'b0;
    snap  = '0;
  end

  assign a = oh_idx(32'(y_sel)) * (1 << (AW/2)) + oh_idx(32'(x_sel));

  // Flux flips appear inside the window; everything else in the read half is transient noise.
  always_comb begin
    if (strobe) sense = in_rd ? snap : mem[a];
    else if (drive_en && !drv_dir) sense = '1;
    else sense = '0;
  end

  always @(posedge clk) begin
    if (drive_en && !drv_dir) begin
      if (!in_rd) snap <= mem[a];
      in_rd  <= 1'b1;
      mem[a] <= '0;
    end else begin
      in_rd <= 1'b0;
    end
    if (drive_en && drv_dir) mem[a] <= FIXED ? wired(a) : ~inhibit;
  end
endmodule

module core_cycle_ctrl_tb;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int XN   = 1 << (AW/2);
  localparam int YN   = 1 << (AW - AW/2);
  localparam int FULL = 4 + 1 + 3 + 2;
  localparam int ZERO = 4 + 2;

  typedef struct { logic [DW-1:0] data; int cyc; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;

  // RAM-plane instance signals
  logic          d_valid, d_ready, d_write, d_zero, d_en, d_dir, d_stb, d_rv, d_busy;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_wdata, d_inh, d_sense, d_rdata;
  logic [XN-1:0] d_x;
  logic [YN-1:0] d_y;
  // Fixed-plane instance signals
  logic          r_valid, r_ready, r_write, r_zero, r_en, r_dir, r_stb, r_rv, r_busy;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata, r_inh, r_sense, r_rdata;
  logic [XN-1:0] r_x;
  logic [YN-1:0] r_y;

  core_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .FIXED_PLANE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_ready(d_ready),
    .req_addr(d_addr), .req_write(d_write), .req_zero(d_zero), .req_wdata(d_wdata),
    .x_sel(d_x), .y_sel(d_y), .drive_en(d_en), .drv_dir(d_dir), .inhibit(d_inh),
    .sense(d_sense), .strobe(d_stb), .rsp_valid(d_rv), .rsp_rdata(d_rdata),
    .busy_prime(d_busy));

  core_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .FIXED_PLANE(1'b1)) u_dut_rom (
    .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_ready(r_ready),
    .req_addr(r_addr), .req_write(r_write), .req_zero(r_zero), .req_wdata(r_wdata),
    .x_sel(r_x), .y_sel(r_y), .drive_en(r_en), .drv_dir(r_dir), .inhibit(r_inh),
    .sense(r_sense), .strobe(r_stb), .rsp_valid(r_rv), .rsp_rdata(r_rdata),
    .busy_prime(r_busy));

  core_plane_model #(.AW(AW), .DW(DW), .FIXED(1'b0)) u_plane_d (
    .clk(clk), .x_sel(d_x), .y_sel(d_y), .drive_en(d_en), .drv_dir(d_dir),
    .inhibit(d_inh), .strobe(d_stb), .sense(d_sense));

  core_plane_model #(.AW(AW), .DW(DW), .FIXED(1'b1)) u_plane_r (
    .clk(clk), .x_sel(r_x), .y_sel(r_y), .drive_en(r_en), .drv_dir(r_dir),
    .inhibit(r_inh), .strobe(r_stb), .sense(r_sense));

  function automatic logic [DW-1:0] wired_word(input int k);
    return DW'((k * 37 + 5) % 256);
  endfunction

  function automatic int onehot_pos(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  exp_t q_d[$];
  exp_t q_r[$];
  int   cur_addr_d = 0;

  // Driver: present a request, wait for the transfer, queue the expected result.
  task automatic send(input bit rom, input int a, input bit w, input bit z,
                      input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                      input int lat, input string tag);
    exp_t e;
    bit   rdy;
    @(negedge clk);
    if (rom) begin
      r_valid = 1; r_addr = AW'(a); r_write = w; r_zero = z; r_wdata = wd;
    end else begin
      d_valid = 1; d_addr = AW'(a); d_write = w; d_zero = z; d_wdata = wd;
    end
    forever begin
      rdy = rom ? r_ready : d_ready;
      e.cyc = cyc + lat;
      if (rdy) break;
      @(negedge clk);
    end
    e.data = exp;
    e.tag  = tag;
    if (rom) q_r.push_back(e);
    else begin
      q_d.push_back(e);
      cur_addr_d = a;
    end
    @(negedge clk);
    if (rom) r_valid = 0; else d_valid = 0;
    // R7: ready low right after the accepting edge
    chk((rom ? r_ready : d_ready) == 1'b0, "R7", "ready after accept",
        rom ? r_ready : d_ready, 0);
  endtask

  // Monitor: compare results and done timing against the queues.
  int  d_rv_run = 0, r_rv_run = 0, pulse_bad = 0;
  int  r1_bad = 0, d_rd_starts = 0, d_stb_cycles = 0;
  int  prime_seen = 0, prime_prev = -1, prime_bad = 0, prime_rsp = 0;
  bit  d_en_prev = 0, r_en_prev = 0;

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (d_rv) begin
        exp_t e;
        if (q_d.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          e = q_d.pop_front();
          chk(d_rdata == e.data, e.tag, "rdata", d_rdata, e.data);
          chk(cyc == e.cyc, "R6", "done cycle", cyc, e.cyc);
        end
      end
      if (r_rv) begin
        exp_t e;
        if (q_r.size() == 0) chk(0, "R10", "unexpected done rom", 1, 0);
        else begin
          e = q_r.pop_front();
          chk(r_rdata == e.data, e.tag, "rdata rom", r_rdata, e.data);
          chk(cyc == e.cyc, "R6", "done cycle rom", cyc, e.cyc);
        end
      end
      d_rv_run = d_rv ? d_rv_run + 1 : 0;
      r_rv_run = r_rv ? r_rv_run + 1 : 0;
      if (d_rv_run > 1 || r_rv_run > 1) pulse_bad++;
      // R1: select lines of the RAM instance
      if (d_en) begin
        if ($countones(d_x) != 1 || $countones(d_y) != 1) r1_bad++;
        else if (onehot_pos(32'(d_y)) * XN + onehot_pos(32'(d_x)) != cur_addr_d) r1_bad++;
      end else if (d_x != 0 || d_y != 0) r1_bad++;
      // R2: strobe window length per read half
      if (d_en && !d_dir && !(d_en_prev && !d_dir)) d_rd_starts++;
      if (d_stb) d_stb_cycles++;
      d_en_prev = d_en;
      // R8: priming order on the fixed plane
      if (r_busy) begin
        if (r_rv) prime_rsp++;
        if (r_en && !r_dir && !r_en_prev) begin
          int pa;
          pa = onehot_pos(32'(r_y)) * XN + onehot_pos(32'(r_x));
          if (pa != prime_prev + 1) prime_bad++;
          prime_prev = pa;
          prime_seen++;
        end
      end
      r_en_prev = r_en && !r_dir;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    d_valid = 0; d_addr = 0; d_write = 0; d_zero = 0; d_wdata = 0;
    r_valid = 0; r_addr = 0; r_write = 0; r_zero = 0; r_wdata = 0;
    repeat (3) @(negedge clk);
    // Reset state
    chk(d_rv == 0, "R10", "reset rsp_valid", d_rv, 0);
    chk(d_en == 0 && d_x == 0 && d_y == 0, "R1", "reset drive", d_en, 0);
    chk(d_busy == 0, "R8", "ram busy_prime", d_busy, 0);
    chk(r_busy == 1, "R8", "rom busy_prime at reset", r_busy, 1);
    rst_n = 1;
    @(negedge clk);
    chk(d_ready == 1, "R7", "ram ready idle", d_ready, 1);
    chk(r_ready == 0, "R8", "rom ready while priming", r_ready, 0);

    // RAM plane
    send(0, 3, 1, 0, 8'hA5, 8'h00, FULL, "R4");
    send(0, 3, 0, 0, 8'h00, 8'hA5, FULL, "R2");
    send(0, 3, 0, 0, 8'h00, 8'hA5, FULL, "R3");
    send(0, 0, 1, 0, 8'h00, 8'h00, FULL, "R4");
    send(0, 15, 1, 0, 8'hFF, 8'h00, FULL, "R4");
    send(0, 7, 1, 0, 8'h3C, 8'h00, FULL, "R4");
    send(0, 0, 0, 0, 8'h00, 8'h00, FULL, "R2");
    send(0, 15, 0, 0, 8'h00, 8'hFF, FULL, "R2");
    send(0, 7, 0, 1, 8'h00, 8'h3C, ZERO, "R5");
    send(0, 7, 0, 0, 8'h00, 8'h00, FULL, "R5");
    send(0, 15, 1, 0, 8'h81, 8'h00, FULL, "R4");
    send(0, 15, 0, 0, 8'h00, 8'h81, FULL, "R3");
    send(0, 9, 1, 0, 8'h5A, 8'h00, FULL, "R4");
    send(0, 9, 0, 0, 8'h00, 8'h5A, FULL, "R1");

    // Fixed plane
    while (r_busy) @(negedge clk);
    chk(prime_seen == 16, "R8", "priming reads", prime_seen, 16);
    chk(prime_bad == 0, "R8", "priming order errors", prime_bad, 0);
    chk(prime_rsp == 0, "R8", "done pulses while priming", prime_rsp, 0);
    send(1, 5, 0, 0, 8'h00, wired_word(5), FULL, "R8");
    send(1, 5, 1, 0, 8'h00, 8'h00, FULL, "R9");
    send(1, 5, 0, 0, 8'h00, wired_word(5), FULL, "R9");
    send(1, 9, 0, 1, 8'h00, wired_word(9), FULL, "R9");
    send(1, 9, 0, 0, 8'h00, wired_word(9), FULL, "R9");
    send(1, 0, 0, 0, 8'h00, wired_word(0), FULL, "R8");
    chk(r_busy == 0, "R8", "busy_prime stays low", r_busy, 0);

    while (q_d.size() != 0 || q_r.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(r1_bad == 0, "R1", "select line violations", r1_bad, 0);
    chk(d_stb_cycles == 2 * d_rd_starts, "R2", "strobe cycles", d_stb_cycles, 2 * d_rd_starts);
    chk(pulse_bad == 0, "R10", "done pulse wider than one cycle", pulse_bad, 0);
    finish_run();
  end

endmodule